// File: doc/BRIEF.md
# Two-Set GPIO Blink Waveform Generator

This block drives the output value of every line in a GPIO bank. Two shared timing sets, A and B, each hold a high-time count and a low-time count in clock cycles. Each set runs a free-running phase machine that alternates a high phase and a low phase. Each line carries a blink-enable bit and a set-select bit. An enabled line follows the waveform of the set it selects. A line with its enable clear drives its static output bit.

Software programs the four duration registers through a single-cycle write strobe. The strobe carries a set bit and a register bit. A new count never shortens the phase that is running. It is loaded only when the next phase of that kind begins. A count of zero is treated as one, so no phase can stall. Direction control and bus decoding sit outside this block.

Top module: `gpio_blink_gen`

## Requirements
- R1: An enabled line on a set programmed with high count H and low count L shows runs of exactly H cycles high and L cycles low, for a period of H+L.
- R2: A line whose blink-enable bit is 0 drives its static output bit in the same cycle, whatever the state of either set.
- R3: A write with `dur_set_i`=0 targets set A and with `dur_set_i`=1 targets set B. `dur_reg_i`=0 selects the high-time register (offset 0x0) and `dur_reg_i`=1 selects the low-time register (offset 0x4).
- R4: A programmed count of 0 behaves exactly like a count of 1.
- R5: Programming one set leaves the run lengths of the other set unchanged.
- R6: A count written during a phase does not change the length of that phase. It takes effect the next time a phase of that kind starts.
- R7: Every enabled line with select bit 0 carries the set A waveform, and every enabled line with select bit 1 carries the set B waveform, so all lines on one set are identical in every cycle.
- R8: During reset both sets sit in the high phase with both counts at 1. Right after reset an enabled line alternates one cycle high and one cycle low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; durations are counted in its cycles |
| rst_n | input | 1 | Active-low asynchronous reset |
| static_out_i | input | NLINES | Static output value for each line |
| blink_en_i | input | NLINES | Per-line blink enable |
| set_sel_i | input | NLINES | Per-line timing set select (0 = A, 1 = B) |
| dur_wr_i | input | 1 | Duration register write strobe |
| dur_set_i | input | 1 | Target set of the write (0 = A, 1 = B) |
| dur_reg_i | input | 1 | Target register (0 = high time, 1 = low time) |
| dur_data_i | input | CW | Duration count to write |
| drive_o | output | NLINES | Value driven onto each line |

## Verification
The bench builds the block with its default parameters: 32 lines and 32-bit counts. The full width lets the same run mix blinking lines on both sets with static lines in one vector, so the routing of each line can be checked against its neighbours. The counts used are short (0 to 10 cycles). This brings the zero-count floor, the reset period of two cycles and a write that lands in the middle of a long phase within a few hundred cycles.

// File: rtl/gpio_blink_pkg.sv
package gpio_blink_pkg;

    typedef enum logic {
        SET_A = 1'b0,
        SET_B = 1'b1
    } blink_set_e;

    typedef enum logic {
        DUR_HIGH = 1'b0,
        DUR_LOW  = 1'b1
    } dur_reg_e;

    localparam int unsigned NUM_SETS = 2;

endpackage

// File: rtl/blink_wr_dec.sv
module blink_wr_dec
    import gpio_blink_pkg::*;
(
    input  logic                wr_i,
    input  logic                set_i,
    input  logic                reg_i,
    output logic [NUM_SETS-1:0] wr_high_o,
    output logic [NUM_SETS-1:0] wr_low_o
);

    always_comb begin
        wr_high_o = '0;
        wr_low_o  = '0;
        for (int s = 0; s < NUM_SETS; s++) begin
            if (wr_i && (set_i == s[0])) begin
                if (dur_reg_e'(reg_i) == DUR_HIGH) wr_high_o[s] = 1'b1;
                else                               wr_low_o[s]  = 1'b1;
            end
        end
    end

endmodule

// File: rtl/blink_timer.sv
module blink_timer #(
    parameter int unsigned CW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_high_i,
    input  logic          wr_low_i,
    input  logic [CW-1:0] data_i,
    output logic          wave_o
);

    localparam logic [CW-1:0] ONE = CW'(1);

    typedef struct packed {
        logic          hi;
        logic [CW-1:0] cnt;
        logic [CW-1:0] len;
        logic [CW-1:0] high_cnt;
        logic [CW-1:0] low_cnt;
    } tmr_state_t;

    tmr_state_t st_d, st_q;
    logic       last_cycle;

    function automatic logic [CW-1:0] floor_one(input logic [CW-1:0] v);
        return (v == '0) ? ONE : v;
    endfunction

    assign last_cycle = (st_q.cnt == st_q.len - ONE);

    always_comb begin
        st_d = st_q;
        if (wr_high_i) st_d.high_cnt = data_i;
        if (wr_low_i)  st_d.low_cnt  = data_i;
        if (last_cycle) begin
            st_d.hi  = ~st_q.hi;
            st_d.cnt = '0;
            st_d.len = st_q.hi ? floor_one(st_q.low_cnt) : floor_one(st_q.high_cnt);
        end else begin
            st_d.cnt = st_q.cnt + ONE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.hi       <= 1'b1;
            st_q.cnt      <= '0;
            st_q.len      <= ONE;
            st_q.high_cnt <= ONE;
            st_q.low_cnt  <= ONE;
        end else begin
            st_q <= st_d;
        end
    end

    assign wave_o = st_q.hi;

    // R1: the phase counter stays inside the current phase length
    p_cnt_in_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt < st_q.len);

    // R4: a loaded phase length is never zero
    p_len_min_r4: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.len != '0);

    // R6: the output holds until the loaded phase length is used up
    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !last_cycle |=> $stable(wave_o));

    // R1: the output toggles at each phase end
    p_flip_r1: assert property (@(posedge clk) disable iff (!rst_n)
        last_cycle |=> (wave_o != $past(wave_o)));

endmodule

// File: rtl/blink_line_mux.sv
module blink_line_mux
    import gpio_blink_pkg::*;
#(
    parameter int unsigned NLINES = 32
) (
    input  logic [NUM_SETS-1:0] wave_i,
    input  logic [NLINES-1:0]   static_i,
    input  logic [NLINES-1:0]   en_i,
    input  logic [NLINES-1:0]   sel_i,
    output logic [NLINES-1:0]   drive_o
);

    for (genvar i = 0; i < NLINES; i++) begin : g_line
        logic picked;
        assign picked     = (blink_set_e'(sel_i[i]) == SET_B) ? wave_i[1] : wave_i[0];
        assign drive_o[i] = en_i[i] ? picked : static_i[i];
    end

endmodule

// File: rtl/gpio_blink_gen.sv
module gpio_blink_gen
    import gpio_blink_pkg::*;
#(
    parameter int unsigned NLINES = 32,
    parameter int unsigned CW     = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NLINES-1:0] static_out_i,
    input  logic [NLINES-1:0] blink_en_i,
    input  logic [NLINES-1:0] set_sel_i,
    input  logic              dur_wr_i,
    input  logic              dur_set_i,
    input  logic              dur_reg_i,
    input  logic [CW-1:0]     dur_data_i,
    output logic [NLINES-1:0] drive_o
);

    logic [NUM_SETS-1:0] wr_high;
    logic [NUM_SETS-1:0] wr_low;
    logic [NUM_SETS-1:0] wave;

    blink_wr_dec i_dec (
        .wr_i      (dur_wr_i),
        .set_i     (dur_set_i),
        .reg_i     (dur_reg_i),
        .wr_high_o (wr_high),
        .wr_low_o  (wr_low)
    );

    for (genvar s = 0; s < NUM_SETS; s++) begin : g_set
        blink_timer #(.CW(CW)) i_timer (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_high_i (wr_high[s]),
            .wr_low_i  (wr_low[s]),
            .data_i    (dur_data_i),
            .wave_o    (wave[s])
        );
    end

    blink_line_mux #(.NLINES(NLINES)) i_mux (
        .wave_i   (wave),
        .static_i (static_out_i),
        .en_i     (blink_en_i),
        .sel_i    (set_sel_i),
        .drive_o  (drive_o)
    );

    // R3: a write strobe reaches at most one duration register
    p_one_target_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({wr_high, wr_low}) <= 1);

    // R2: with no line blinking, the drive vector is the static vector
    p_static_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (blink_en_i == '0) |-> (drive_o == static_out_i));

endmodule

// File: tb/test_gpio_blink_gen.sv
`timescale 1ns/1ps
module test_gpio_blink_gen;

    localparam int NL = 32;
    localparam int CWB = 32;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [NL-1:0]  static_out = '0;
    logic [NL-1:0]  blink_en = '0;
    logic [NL-1:0]  set_sel = '0;
    logic           dur_wr = 1'b0;
    logic           dur_set = 1'b0;
    logic           dur_reg = 1'b0;
    logic [CWB-1:0] dur_data = '0;
    logic [NL-1:0]  drive;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    gpio_blink_gen #(.NLINES(NL), .CW(CWB)) i_gpio_blink_gen (
        .clk          (clk),
        .rst_n        (rst_n),
        .static_out_i (static_out),
        .blink_en_i   (blink_en),
        .set_sel_i    (set_sel),
        .dur_wr_i     (dur_wr),
        .dur_set_i    (dur_set),
        .dur_reg_i    (dur_reg),
        .dur_data_i   (dur_data),
        .drive_o      (drive)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic s, input logic r, input logic [CWB-1:0] v);
        @(negedge clk);
        dur_wr = 1'b1; dur_set = s; dur_reg = r; dur_data = v;
        @(negedge clk);
        dur_wr = 1'b0;
    endtask

    // wait for a rising edge on a line, then count the high and low runs
    task automatic measure(input int ln, output int hi, output int lo);
        int guard = 0;
        hi = 0; lo = 0;
        @(negedge clk);
        while (drive[ln] !== 1'b0 && guard < 500) begin @(negedge clk); guard++; end
        while (drive[ln] !== 1'b1 && guard < 500) begin @(negedge clk); guard++; end
        while (drive[ln] === 1'b1 && guard < 500) begin hi++; @(negedge clk); guard++; end
        while (drive[ln] === 1'b0 && guard < 500) begin lo++; @(negedge clk); guard++; end
    endtask

    task automatic t_reset();
        int hi, lo;
        static_out = 32'h0000_00F0;
        blink_en   = 32'h0000_0001;
        set_sel    = 32'h0000_0000;
        repeat (3) @(negedge clk);
        check("R8 reset phase high", drive[0], 1'b1);
        check("R2 static during reset", drive[31:1], static_out[31:1]);
        rst_n = 1'b1;
        measure(0, hi, lo);
        check("R8 post-reset high run", hi, 1);
        check("R8 post-reset low run", lo, 1);
    endtask

    task automatic t_static();
        blink_en = '0;
        static_out = 32'hA5C3_0F96;
        @(negedge clk);
        check("R2 static pattern 1", drive, 32'hA5C3_0F96);
        static_out = 32'h5A3C_F069;
        set_sel = '1;
        repeat (3) @(negedge clk);
        check("R2 static pattern 2", drive, 32'h5A3C_F069);
    endtask

    task automatic t_set_a();
        int hi, lo;
        blink_en = 32'h0000_0010;
        set_sel  = 32'h0000_0000;
        wr(1'b0, 1'b0, 3);
        wr(1'b0, 1'b1, 5);
        repeat (12) @(negedge clk);
        measure(4, hi, lo);
        check("R1 R3 set A high run", hi, 3);
        check("R1 R3 set A low run", lo, 5);
    endtask

    task automatic t_set_b();
        int hi, lo;
        blink_en = 32'h0000_0030;
        set_sel  = 32'h0000_0020;
        wr(1'b1, 1'b0, 7);
        wr(1'b1, 1'b1, 2);
        repeat (12) @(negedge clk);
        measure(5, hi, lo);
        check("R3 set B high run", hi, 7);
        check("R3 set B low run", lo, 2);
        measure(4, hi, lo);
        check("R5 set A high unchanged", hi, 3);
        check("R5 set A low unchanged", lo, 5);
    endtask

    task automatic t_zero();
        int hi, lo;
        blink_en = 32'h0000_0020;
        set_sel  = 32'h0000_0020;
        wr(1'b1, 1'b0, 0);
        wr(1'b1, 1'b1, 4);
        repeat (15) @(negedge clk);
        measure(5, hi, lo);
        check("R4 zero high count", hi, 1);
        check("R4 low run", lo, 4);
        wr(1'b1, 1'b1, 0);
        repeat (10) @(negedge clk);
        measure(5, hi, lo);
        check("R4 zero both high", hi, 1);
        check("R4 zero both low", lo, 1);
    endtask

    task automatic t_midwrite();
        int hi, lo, guard;
        blink_en = 32'h0000_0100;
        set_sel  = 32'h0000_0000;
        wr(1'b0, 1'b0, 10);
        wr(1'b0, 1'b1, 10);
        repeat (30) @(negedge clk);
        guard = 0;
        while (drive[8] !== 1'b0 && guard < 100) begin @(negedge clk); guard++; end
        while (drive[8] !== 1'b1 && guard < 100) begin @(negedge clk); guard++; end
        hi = 1;
        dur_wr = 1'b1; dur_set = 1'b0; dur_reg = 1'b0; dur_data = 3;
        @(negedge clk);
        dur_wr = 1'b0;
        while (drive[8] === 1'b1 && guard < 100) begin hi++; @(negedge clk); guard++; end
        check("R6 running phase kept", hi, 10);
        measure(8, hi, lo);
        check("R6 new high at next phase", hi, 3);
        check("R6 low unchanged", lo, 10);
    endtask

    task automatic t_lines();
        logic [NL-1:0] exp;
        bit seen_diff = 1'b0;
        wr(1'b0, 1'b0, 2);
        wr(1'b0, 1'b1, 3);
        wr(1'b1, 1'b0, 5);
        wr(1'b1, 1'b1, 1);
        static_out = 32'h1234_5678;
        blink_en   = 32'hF0F0_FF00;
        set_sel    = 32'hCC33_AA55;
        repeat (20) @(negedge clk);
        for (int c = 0; c < 40; c++) begin
            for (int i = 0; i < NL; i++)
                exp[i] = blink_en[i] ? (set_sel[i] ? drive[9] : drive[8]) : static_out[i];
            if (drive[8] != drive[9]) seen_diff = 1'b1;
            check("R7 per-line routing", drive, exp);
            @(negedge clk);
        end
        check("R7 sets differ", seen_diff, 1'b1);
    endtask

    initial begin
        t_reset();
        t_static();
        t_set_a();
        t_set_b();
        t_zero();
        t_midwrite();
        t_lines();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule